// File: doc/BRIEF.md
# GPIO pad bank controller

The block controls a bank of general-purpose I/O pads through a 32-bit register bus. Every pad has a 16-byte group of four words. Two are configuration words. The first of these holds a 3-bit function-select field and three interrupt trigger bits. The third word is a value word, which holds active-low input and output enables and the pad level. The fourth is a default word that software may use freely. Pad inputs cross into the clock domain through a chain of synchronizer flops. The block then checks each synchronized sample against the trigger selected for that pad.

Detected events are held in pending flags. The pending flags are grouped 32 pads to a status word in a separate region starting at 0x800. Software clears a flag by writing 1 to it. One interrupt line is driven whenever any flag is pending. The number of pads is a parameter. Electrical pad settings, pull resistors, alternate-function routing and logical-to-pad numbering are left to other blocks.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every configuration and default word reads 0. Every value word reads 0x6: both enables are inactive and the level reads 0. Every status word reads 0, irq is 0 and all pad_oe bits are 0.
- R2: Pad p owns the bytes at p*16. The first configuration word is at +0x0, the second at +0x4, the value word at +0x8 and the default word at +0xC. Both configuration words and the default word read back all 32 written bits, and a write to one pad leaves the neighbouring pad unchanged.
- R3: In the value word, bit 2 is the input enable and bit 1 is the output enable, both active low. pad_oe is high exactly when bit 1 is 0. pad_out carries the written bit 0. Bits 31:3 read back as written.
- R4: Value word bit 0 reads the pad input after two synchronizer flops. A change made before clock edge k is first visible after edge k+1. While bit 2 is 1, bit 0 reads 0.
- R5: With configuration bit 24 clear, the trigger is set by bits 25 and 26. Bit 25 alone detects rising edges, bit 26 alone detects falling edges, and both together detect either edge. An edge is a difference between two consecutive synchronized samples. An input change before edge k sets the pending flag at edge k+2.
- R6: With bit 24 set, bit 25 selects high-level and bit 26 selects low-level detection. A pad whose level condition still holds stays pending after software clears it.
- R7: Bit 24 alone, or all three trigger bits clear, detects nothing. A pad whose input enable is inactive raises no event.
- R8: The pending flag of pad p is bit p mod 32 of the status word at 0x800 + (p/32)*4. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: An event and a clear of the same flag in the same cycle leave the flag set.
- R10: irq is high exactly when at least one pending flag is set, from the cycle after that flag is set.
- R11: Reads of unmapped or unaligned addresses return 0, and writes to them change nothing. This covers pad groups at or beyond NUM_PADS, the gap below 0x800, and status words beyond the last pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Driven pad levels |
| pad_oe | output | NUM_PADS | Pad driver enables, 0 = tri-state |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take a bus access to last exactly one cycle, with address and data stable across the sampling edge. They also take pad inputs to change only between edges, so each change has a well-defined first sampling edge. The stimulus changes bus signals and pad inputs on the falling clock edge only, and it holds every access for one full cycle. Under these conditions the pending-flag timing is exact to the cycle, and the bench can count edges from a pad change to the status bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int DATA_W         = 32;
   localparam int GROUP_BYTES    = 16;
   localparam int STAT_WORD_PADS = 32;

   // trigger bit positions in the first configuration word
   localparam int CFG_FALL  = 26;
   localparam int CFG_RISE  = 25;
   localparam int CFG_LEVEL = 24;

   // value word bit positions
   localparam int VAL_IEN_N = 2;
   localparam int VAL_OEN_N = 1;
   localparam int VAL_LEVEL = 0;

   typedef enum logic [1:0] {
      SEL_CFG_A   = 2'd0,
      SEL_CFG_B   = 2'd1,
      SEL_VALUE   = 2'd2,
      SEL_DEFAULT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic fall;
      logic rise;
      logic level;
   } trig_t;

   // level mode reuses rise/fall as polarity selects
   function automatic logic trig_fire(trig_t t, logic cur, logic prev);
      if (t.level)
         return (t.rise & cur) | (t.fall & ~cur);
      return (t.rise & cur & ~prev) | (t.fall & ~cur & prev);
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         chain_q <= '0;
      else
         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_slice.sv
module gpio_pad_slice
   import gpio_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pad_s,
   output logic [DATA_W-1:0] rdata,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              ien_n,
   output logic              evt
);

   logic [DATA_W-1:0] cfg_a_q;
   logic [DATA_W-1:0] cfg_b_q;
   logic [DATA_W-1:0] dflt_q;
   logic [DATA_W-1:3] val_hi_q;
   logic              ien_n_q;
   logic              oen_n_q;
   logic              drv_q;
   logic              prev_q;
   trig_t             trig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_a_q  <= '0;
         cfg_b_q  <= '0;
         dflt_q   <= '0;
         val_hi_q <= '0;
         ien_n_q  <= 1'b1;
         oen_n_q  <= 1'b1;
         drv_q    <= 1'b0;
      end else if (wr_en) begin
         unique case (sel)
            SEL_CFG_A:   cfg_a_q <= wdata;
            SEL_CFG_B:   cfg_b_q <= wdata;
            SEL_VALUE: begin
               val_hi_q <= wdata[DATA_W-1:3];
               ien_n_q  <= wdata[VAL_IEN_N];
               oen_n_q  <= wdata[VAL_OEN_N];
               drv_q    <= wdata[VAL_LEVEL];
            end
            SEL_DEFAULT: dflt_q  <= wdata;
         endcase
      end
   end

   // previous synchronized sample for edge detection
   always_ff @(posedge clk) begin
      if (!rst_n)
         prev_q <= 1'b0;
      else
         prev_q <= pad_s;
   end

   assign trig = '{fall:  cfg_a_q[CFG_FALL],
                   rise:  cfg_a_q[CFG_RISE],
                   level: cfg_a_q[CFG_LEVEL]};

   assign evt = ~ien_n_q & trig_fire(trig, pad_s, prev_q);

   always_comb begin
      unique case (sel)
         SEL_CFG_A:   rdata = cfg_a_q;
         SEL_CFG_B:   rdata = cfg_b_q;
         SEL_VALUE:   rdata = {val_hi_q, ien_n_q, oen_n_q, pad_s & ~ien_n_q};
         SEL_DEFAULT: rdata = dflt_q;
      endcase
   end

   assign pad_out = drv_q;
   assign pad_oe  = ~oen_n_q;
   assign ien_n   = ien_n_q;

endmodule

// File: rtl/gpio_status_bank.sv
module gpio_status_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PADS = 40,
   parameter int WIDX_W   = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_en,
   input  logic [WIDX_W-1:0]   word_idx,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [NUM_PADS-1:0] evt,
   output logic [NUM_PADS-1:0] st
);

   logic [NUM_PADS-1:0] clr_vec;

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_clr
      localparam int WORD = i / STAT_WORD_PADS;
      localparam int BIT  = i % STAT_WORD_PADS;
      assign clr_vec[i] = clr_en && (word_idx == WIDX_W'(WORD)) && wdata[BIT];
   end

   // a new event outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)
         st <= '0;
      else
         st <= (st & ~clr_vec) | evt;
   end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PADS    = 40,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PADS-1:0] pad_in,
   output logic [NUM_PADS-1:0] pad_out,
   output logic [NUM_PADS-1:0] pad_oe,
   output logic                irq
);

   localparam int NUM_WORDS = (NUM_PADS + STAT_WORD_PADS - 1) / STAT_WORD_PADS;
   localparam int PIDX_W    = ADDR_W - 5;
   localparam int WIDX_W    = ADDR_W - 3;
   localparam int ST_BITS   = NUM_WORDS * STAT_WORD_PADS;

   generate
      if (NUM_PADS < 1) begin : g_bad_pads
         $error("NUM_PADS must be at least 1");
      end
      if (NUM_PADS * GROUP_BYTES > (1 << (ADDR_W - 1))) begin : g_bad_span
         $error("pad groups overlap the status region");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // address decode
   logic              aligned;
   logic              pad_hit;
   logic              stat_hit;
   logic [PIDX_W-1:0] pad_idx;
   logic [WIDX_W-1:0] word_idx;
   reg_sel_e          sel;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign pad_idx  = bus_addr[ADDR_W-2:4];
   assign word_idx = bus_addr[ADDR_W-2:2];
   assign sel      = reg_sel_e'(bus_addr[3:2]);
   assign pad_hit  = aligned && !bus_addr[ADDR_W-1] && (int'(pad_idx) < NUM_PADS);
   assign stat_hit = aligned &&  bus_addr[ADDR_W-1] && (int'(word_idx) < NUM_WORDS);

   // input synchronizer
   logic [NUM_PADS-1:0] pad_s;

   gpio_sync #(
      .WIDTH  (NUM_PADS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_s)
   );

   // per-pad register groups
   logic [DATA_W-1:0]   slice_rd [NUM_PADS];
   logic [NUM_PADS-1:0] evt_vec;
   logic [NUM_PADS-1:0] ien_n_vec;

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      logic wr_i;
      assign wr_i = bus_en && bus_we && pad_hit && (pad_idx == PIDX_W'(i));

      gpio_pad_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_i),
         .sel     (sel),
         .wdata   (bus_wdata),
         .pad_s   (pad_s[i]),
         .rdata   (slice_rd[i]),
         .pad_out (pad_out[i]),
         .pad_oe  (pad_oe[i]),
         .ien_n   (ien_n_vec[i]),
         .evt     (evt_vec[i])
      );
   end

   // pending flags
   logic [NUM_PADS-1:0] status_q;

   gpio_status_bank #(
      .NUM_PADS (NUM_PADS),
      .WIDX_W   (WIDX_W)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (bus_en && bus_we && stat_hit),
      .word_idx (word_idx),
      .wdata    (bus_wdata),
      .evt      (evt_vec),
      .st       (status_q)
   );

   assign irq = |status_q;

   // read path
   logic [ST_BITS-1:0] st_ext;

   always_comb begin
      st_ext                = '0;
      st_ext[NUM_PADS-1:0]  = status_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         if (pad_hit) begin
            for (int i = 0; i < NUM_PADS; i++)
               if (pad_idx == PIDX_W'(i)) bus_rdata = slice_rd[i];
         end else if (stat_hit) begin
            for (int w = 0; w < NUM_WORDS; w++)
               if (word_idx == WIDX_W'(w))
                  bus_rdata = st_ext[w*STAT_WORD_PADS +: STAT_WORD_PADS];
         end
      end
   end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int NUM_PADS = 40,
   parameter int ADDR_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic [31:0]         bus_rdata,
   input  logic                irq,
   input  logic [NUM_PADS-1:0] pad_oe,
   input  logic [NUM_PADS-1:0] st,
   input  logic [NUM_PADS-1:0] evt,
   input  logic [NUM_PADS-1:0] ien_n
);

   localparam int NUM_WORDS = (NUM_PADS + 31) / 32;

   logic              aligned;
   logic              pad_area;
   logic              stat_area;
   logic              wr_stat;
   logic [ADDR_W-4:0] widx;

   always_comb begin
      aligned   = (bus_addr[1:0] == 2'b00);
      widx      = bus_addr[ADDR_W-2:2];
      pad_area  = aligned && (int'(bus_addr) < NUM_PADS * 16);
      stat_area = aligned && bus_addr[ADDR_W-1] && (int'(widx) < NUM_WORDS);
      wr_stat   = bus_en && bus_we && stat_area;
   end

   // R11
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && !pad_area && !stat_area) |-> (bus_rdata == 32'h0));

   // R10
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|evt));

   // R10
   irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_en && bus_we && bus_addr[ADDR_W-1]));

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      localparam int WORD = i / 32;
      localparam int BIT  = i % 32;
      logic clr_i;
      logic val_wr_i;
      assign clr_i    = wr_stat && (int'(widx) == WORD) && bus_wdata[BIT];
      assign val_wr_i = bus_en && bus_we && (int'(bus_addr) == i * 16 + 8);

      // R9
      event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> st[i]);

      // R8
      clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !evt[i]) |=> !st[i]);

      // R8
      pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (st[i] && !clr_i) |=> st[i]);

      // R7
      disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ien_n[i] |-> !evt[i]);

      // R3
      oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         val_wr_i |=> (pad_oe[i] == !$past(bus_wdata[1])));
   end

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
   .NUM_PADS (NUM_PADS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .pad_oe    (pad_oe),
   .st        (status_q),
   .evt       (evt_vec),
   .ien_n     (ien_n_vec)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;

   localparam int NP = 40;
   localparam int NW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gpio_bank_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq       (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0]   m_cfg_a [NP];
   logic [31:0]   m_cfg_b [NP];
   logic [31:0]   m_dflt  [NP];
   logic [31:0]   m_val   [NP];
   logic [NP-1:0] m_sy1, m_s, m_p, m_st;

   always @(posedge clk) begin : model
      logic [NP-1:0] ev;
      logic [NP-1:0] clr;
      int a;
      if (!rst_n) begin
         for (int i = 0; i < NP; i++) begin
            m_cfg_a[i] = 0; m_cfg_b[i] = 0; m_dflt[i] = 0; m_val[i] = 32'h6;
         end
         m_sy1 = '0; m_s = '0; m_p = '0; m_st = '0;
      end else begin
         a = int'(bus_addr);
         for (int i = 0; i < NP; i++) begin
            logic lv, rs, fl;
            lv = m_cfg_a[i][24]; rs = m_cfg_a[i][25]; fl = m_cfg_a[i][26];
            if (m_val[i][2]) ev[i] = 1'b0;
            else if (lv) ev[i] = (rs && m_s[i]) || (fl && !m_s[i]);
            else ev[i] = (rs && m_s[i] && !m_p[i]) || (fl && !m_s[i] && m_p[i]);
            clr[i] = bus_en && bus_we && a[1:0] == 2'b00 && a >= 'h800
                     && (a - 'h800) / 4 == i / 32 && bus_wdata[i % 32];
         end
         m_st = (m_st & ~clr) | ev;
         m_p  = m_s;
         m_s  = m_sy1;
         m_sy1 = pad_in;
         if (bus_en && bus_we && a[1:0] == 2'b00 && a < NP * 16) begin
            case ((a / 4) % 4)
               0: m_cfg_a[a / 16] = bus_wdata;
               1: m_cfg_b[a / 16] = bus_wdata;
               2: m_val[a / 16]   = bus_wdata;
               default: m_dflt[a / 16] = bus_wdata;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [11:0] addr);
      logic [31:0] r;
      int a;
      r = '0;
      a = int'(addr);
      if (a % 4 != 0) return r;
      if (a < NP * 16) begin
         case ((a / 4) % 4)
            0: r = m_cfg_a[a / 16];
            1: r = m_cfg_b[a / 16];
            2: r = {m_val[a / 16][31:1], m_s[a / 16] & ~m_val[a / 16][2]};
            default: r = m_dflt[a / 16];
         endcase
      end else if (a >= 'h800 && (a - 'h800) / 4 < NW) begin
         for (int i = 0; i < NP; i++)
            if (i / 32 == (a - 'h800) / 4) r[i % 32] = m_st[i];
      end
      return r;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = !m_val[i][1];
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_out();
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = m_val[i][0];
      return v;
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-cycle comparison of registered outputs (R10, R3)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R10 irq vs model", 64'(irq), 64'(|m_st));
         check("R3 pad_oe vs model", 64'(pad_oe), 64'(exp_oe()));
         check("R3 pad_out vs model", 64'(pad_out), 64'(exp_out()));
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      check(tag, 64'(bus_rdata), 64'(exp_read(a)));
      bus_en = 1'b0;
   endtask

   task automatic rdc(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      check(tag, 64'(bus_rdata), 64'(e));
      check({tag, " model"}, 64'(bus_rdata), 64'(exp_read(a)));
      bus_en = 1'b0;
   endtask

   task automatic pin(input int i, input logic v);
      @(negedge clk);
      pad_in[i] = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rdc(12'h000, 32'h0, "R1 cfg_a pad0");
      rdc(12'h008, 32'h6, "R1 value pad0");
      rdc(12'h278, 32'h6, "R1 value pad39");
      rdc(12'h800, 32'h0, "R1 status word0");
      rdc(12'h804, 32'h0, "R1 status word1");
      check("R1 irq", 64'(irq), 64'(0));
      check("R1 pad_oe", 64'(pad_oe), 64'(0));

      // R2 layout and readback
      wr(12'h054, 32'hA5A5_0F0F);
      wr(12'h05C, 32'h1234_5678);
      wr(12'h270, 32'h0000_0005);
      rdc(12'h054, 32'hA5A5_0F0F, "R2 cfg_b pad5");
      rdc(12'h05C, 32'h1234_5678, "R2 default pad5");
      rdc(12'h270, 32'h0000_0005, "R2 cfg_a pad39");
      rdc(12'h064, 32'h0, "R2 neighbour pad6");
      rdc(12'h050, 32'h0, "R2 cfg_a pad5 untouched");

      // R3 value word, enables, preserved bits
      wr(12'h038, 32'hFFFF_FFF9);
      idle(1);
      check("R3 oe pad3 on", 64'(pad_oe[3]), 64'(1));
      check("R3 out pad3", 64'(pad_out[3]), 64'(1));
      rdc(12'h038, 32'hFFFF_FFF8, "R3 value readback");
      pin(3, 1'b1);
      idle(3);
      rdc(12'h038, 32'hFFFF_FFF9, "R4 level pad3");
      wr(12'h038, 32'hFFFF_FFFB);
      idle(1);
      check("R3 oe pad3 off", 64'(pad_oe[3]), 64'(0));

      // R4 synchronizer latency and disabled input
      wr(12'h078, 32'h2);
      pin(7, 1'b1);
      rdc(12'h078, 32'h2, "R4 one edge later");
      rdc(12'h078, 32'h3, "R4 two edges later");
      wr(12'h078, 32'h6);
      rdc(12'h078, 32'h6, "R4 input disabled");

      // R5 edge triggers on pad 8
      wr(12'h088, 32'h2);
      wr(12'h080, 32'h0200_0000);
      idle(3);
      pin(8, 1'b1);
      idle(1);
      rdc(12'h800, 32'h0, "R5 not yet pending");
      idle(1);
      rd(12'h800, "R5 rising");
      check("R5 rising bit", 64'(exp_read(12'h800)), 64'(32'h100));
      wr(12'h800, 32'h100);
      rdc(12'h800, 32'h0, "R8 cleared");
      pin(8, 1'b0);
      idle(3);
      rdc(12'h800, 32'h0, "R5 fall ignored by rising");
      wr(12'h080, 32'h0400_0000);
      pin(8, 1'b1);
      idle(3);
      rdc(12'h800, 32'h0, "R5 rise ignored by falling");
      pin(8, 1'b0);
      idle(3);
      rdc(12'h800, 32'h100, "R5 falling");
      wr(12'h800, 32'h100);
      wr(12'h080, 32'h0600_0000);
      pin(8, 1'b1);
      idle(3);
      rdc(12'h800, 32'h100, "R5 both rise");
      wr(12'h800, 32'h100);
      pin(8, 1'b0);
      idle(3);
      rdc(12'h800, 32'h100, "R5 both fall");
      wr(12'h800, 32'h100);
      rdc(12'h800, 32'h0, "R5 cleared");

      // R6 level triggers, R9 clear against live event
      wr(12'h218, 32'h2);
      wr(12'h210, 32'h0300_0000);
      idle(2);
      rdc(12'h804, 32'h0, "R6 high level idle");
      pin(33, 1'b1);
      idle(3);
      rdc(12'h804, 32'h2, "R6 high level");
      wr(12'h804, 32'h2);
      rdc(12'h804, 32'h2, "R9 clear while held");
      pin(33, 1'b0);
      idle(3);
      wr(12'h804, 32'h2);
      rdc(12'h804, 32'h0, "R6 released and cleared");
      wr(12'h228, 32'h2);
      wr(12'h220, 32'h0500_0000);
      idle(2);
      rdc(12'h804, 32'h4, "R6 low level");
      pin(34, 1'b1);
      idle(3);
      wr(12'h804, 32'h4);
      rdc(12'h804, 32'h0, "R6 low released");
      wr(12'h220, 32'h0);

      // R7 no detection
      wr(12'h0A8, 32'h2);
      wr(12'h0A0, 32'h0100_0000);
      pin(10, 1'b1);
      idle(3);
      pin(10, 1'b0);
      idle(3);
      rdc(12'h800, 32'h0, "R7 level bit alone");
      wr(12'h0B0, 32'h0600_0000);
      pin(11, 1'b1);
      idle(3);
      pin(11, 1'b0);
      idle(3);
      rdc(12'h800, 32'h0, "R7 input disabled");

      // R8 write-one-to-clear selectivity
      wr(12'h0C8, 32'h2);
      wr(12'h0C0, 32'h0200_0000);
      pin(8, 1'b1);
      pin(12, 1'b1);
      idle(3);
      rdc(12'h800, 32'h1100, "R8 two pending");
      wr(12'h800, 32'h0);
      rdc(12'h800, 32'h1100, "R8 zero write no effect");
      wr(12'h800, 32'h100);
      rdc(12'h800, 32'h1000, "R8 single bit cleared");
      wr(12'h800, 32'hFFFF_FFFF);
      rdc(12'h800, 32'h0, "R8 all ones");

      // R11 unmapped space
      wr(12'h238, 32'h2);
      wr(12'h230, 32'h0200_0000);
      pin(35, 1'b1);
      idle(3);
      rdc(12'h804, 32'h8, "R11 setup pending");
      wr(12'h808, 32'hFFFF_FFFF);
      rdc(12'h804, 32'h8, "R11 write past last word");
      rdc(12'h808, 32'h0, "R11 read past last word");
      wr(12'h280, 32'hFFFF_FFFF);
      rdc(12'h280, 32'h0, "R11 pad beyond count");
      rdc(12'h270, 32'h5, "R11 last pad intact");
      rdc(12'h802, 32'h0, "R11 unaligned");
      rdc(12'h400, 32'h0, "R11 gap");
      wr(12'h804, 32'h8);
      idle(1);
      check("R10 irq low when nothing pending", 64'(irq), 64'(0));

      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule